// File: doc/BRIEF.md
# Command Mailbox with Argument Collector

This block is a register-mapped command front end. Software writes a command code to a command register and then streams 32-bit argument words into a data register. The block counts the arriving words. Once the collected byte count (words times four) reaches the size that the command requires, it raises a one-cycle execute strobe. The strobe carries the command code and the collected words. The result value that the handler returns in that same cycle is latched into a readable status register.

The handlers sit outside the block. A command with no arguments fires at once, in the cycle of the command write. Any other command fires in the cycle of the data write that completes its arguments.

The control is a two-state machine:
- `MB_IDLE`: no command is pending, and the current code is the reserved code 0.
- `MB_COLLECT`: a valid command is waiting for its arguments.

Its transitions are:
- `arm`: command write of a code that needs data, from either state to `MB_COLLECT`.
- `fire_now`: command write of a code that needs no data, to `MB_IDLE`.
- `complete`: data write that satisfies the byte count, `MB_COLLECT` to `MB_IDLE`.
- `stray`: data write in `MB_IDLE`, which fires the reserved command and stays in `MB_IDLE`.
- `accumulate`: data write that does not yet satisfy the count, staying in `MB_COLLECT`.

Top module: `cmd_mailbox`

## Requirements
- R1: A written command value v is accepted as code v only if 0 < v < NUM_CMDS (default 10). Any other 32-bit value is replaced by reserved code 0, which fires at once.
- R2: A command write of a code that needs arguments clears the word counter and sets status to 32'hFFFF_FFFE (need data) after that clock edge.
- R3: A command whose required byte count is zero fires `exec_valid` combinationally in the same cycle as its command write, with `exec_cmd` equal to the code.
- R4: A data write stores its word at the counter position and increments the counter. `exec_valid` fires in the cycle of the data write that makes (words × 4) ≥ the required bytes. `exec_args` carries word i at bits [32i+31:32i], including the word being written.
- R5: After a firing edge, status holds the `exec_result` value sampled in the firing cycle, the counter is 0, and the current command returns to reserved code 0.
- R6: The reserved code needs zero bytes. When it fires, status becomes 32'hFFFF_FFFF (fail) whatever `exec_result` is. A data write with no command pending fires code 0.
- R7: The default size table is:
  - code 1 (configure): 24 bytes (6 words)
  - code 4: 32 bytes
  - code 5: 8 bytes
  - code 7: 16 bytes
  - code 9: 8 bytes
  - codes 2, 3, 6 (bus reset) and 8 (adapter reset): 0 bytes
- R8: A data write when MAX_WORDS words are already held is dropped and sets `arg_overflow`. The flag stays set until the next command write clears it.
- R9: Register offsets are: 0x00 command (write), 0x04 data (write), 0x08 status (read). All accesses are full 32-bit little-endian words. Reads of any other offset return 0, and writes to any other offset change nothing.
- R10: After reset, status is 32'h0000_0000 (success), no command is pending, `exec_valid` is 0 and `arg_overflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 8 | Write byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rd_addr | input | 8 | Read byte offset |
| reg_rdata | output | 32 | Read data (combinational) |
| exec_valid | output | 1 | One-cycle execute strobe |
| exec_cmd | output | CMD_W (4) | Code of the firing command |
| exec_args | output | MAX_WORDS*32 (256) | Collected argument words |
| exec_result | input | 32 | Handler result, sampled when exec_valid is high |
| arg_overflow | output | 1 | Sticky flag for a dropped argument word |

## Verification
A wrong counter or a wrong current-code register shows at the ports in the very next firing cycle. The strobe then fires one data write too early or too late, carries the wrong code, or the arguments appear in shifted positions, and the status read one cycle later holds the need-data or fail value instead of the handler result. A stale overflow flag or a status that failed to update is visible on the first read after the offending write. A reference model in the bench follows every write, so any drift is flagged within one cycle of the first operation that depends on it.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic [0:0] {
        MB_IDLE    = 1'b0,
        MB_COLLECT = 1'b1
    } mb_state_e;

    localparam int          MB_ADDR_W     = 8;
    localparam logic [7:0]  MB_OFF_CMD    = 8'h00;
    localparam logic [7:0]  MB_OFF_DATA   = 8'h04;
    localparam logic [7:0]  MB_OFF_STATUS = 8'h08;

    localparam logic [31:0] MB_ST_OK   = 32'h0000_0000;
    localparam logic [31:0] MB_ST_FAIL = 32'hFFFF_FFFF;
    localparam logic [31:0] MB_ST_NEED = 32'hFFFF_FFFE;
endpackage

// File: rtl/mbx_cmd_decode.sv
module mbx_cmd_decode #(
    parameter int NUM_CMDS = 10,
    parameter int CMD_W    = 4,
    parameter logic [NUM_CMDS-1:0][7:0] REQ_BYTES = '0
) (
    input  logic [31:0]      wr_value,
    input  logic [CMD_W-1:0] cur_code,
    output logic [CMD_W-1:0] new_code,
    output logic [7:0]       new_req,
    output logic [7:0]       cur_req
);
    function automatic logic [7:0] lookup(input logic [CMD_W-1:0] c);
        logic [7:0] r;
        r = 8'd0;
        for (int k = 0; k < NUM_CMDS; k++) begin
            if (c == CMD_W'(k)) r = REQ_BYTES[k];
        end
        return r;
    endfunction

    logic code_ok;
    assign code_ok  = (wr_value != 32'd0) && (wr_value < 32'(NUM_CMDS));
    assign new_code = code_ok ? wr_value[CMD_W-1:0] : '0;
    assign new_req  = lookup(new_code);
    assign cur_req  = lookup(cur_code);
endmodule

// File: rtl/mbx_arg_buffer.sv
module mbx_arg_buffer #(
    parameter int MAX_WORDS = 8,
    parameter int CNT_W     = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   push,
    input  logic [31:0]            push_data,
    input  logic                   clr_cnt,
    input  logic                   clr_ovf,
    output logic [CNT_W-1:0]       cnt_q,
    output logic [CNT_W-1:0]       cnt_next,
    output logic                   ovf_q,
    output logic [MAX_WORDS*32-1:0] args_view
);
    logic        has_room;
    logic [31:0] words_q [MAX_WORDS];

    assign has_room = (cnt_q < CNT_W'(MAX_WORDS));
    assign cnt_next = (push && has_room) ? cnt_q + CNT_W'(1) : cnt_q;

    generate
        for (genvar i = 0; i < MAX_WORDS; i++) begin : g_word
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    words_q[i] <= '0;
                end else if (push && has_room && (cnt_q == CNT_W'(i))) begin
                    words_q[i] <= push_data;
                end
            end
            assign args_view[32*i +: 32] =
                (push && (cnt_q == CNT_W'(i))) ? push_data : words_q[i];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            cnt_q <= clr_cnt ? '0 : cnt_next;
            if (clr_ovf) begin
                ovf_q <= 1'b0;
            end else if (push && !has_room) begin
                ovf_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mbx_fsm.sv
module mbx_fsm
    import mbx_pkg::*;
#(
    parameter int CMD_W = 4,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic             data_wr,
    input  logic [CMD_W-1:0] new_code,
    input  logic [7:0]       new_req,
    input  logic [7:0]       cur_req,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic [31:0]      result,
    output mb_state_e        state_q,
    output logic [CMD_W-1:0] cur_code_q,
    output logic [31:0]      status_q,
    output logic             fire,
    output logic [CMD_W-1:0] fire_code
);
    mb_state_e        state_d;
    logic [CMD_W-1:0] code_d;
    logic [31:0]      status_d;
    logic             enough;

    assign enough = (32'({cnt_next, 2'b00}) >= 32'(cur_req));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= MB_IDLE;
            cur_code_q <= '0;
            status_q   <= MB_ST_OK;
        end else begin
            state_q    <= state_d;
            cur_code_q <= code_d;
            status_q   <= status_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        code_d    = cur_code_q;
        status_d  = status_q;
        fire      = 1'b0;
        fire_code = cur_code_q;
        if (cmd_wr) begin
            if (new_req == 8'd0) begin
                // fire_now
                fire      = 1'b1;
                fire_code = new_code;
                status_d  = (new_code == '0) ? MB_ST_FAIL : result;
                state_d   = MB_IDLE;
                code_d    = '0;
            end else begin
                // arm
                status_d  = MB_ST_NEED;
                state_d   = MB_COLLECT;
                code_d    = new_code;
            end
        end else if (data_wr) begin
            unique case (state_q)
                MB_IDLE: begin
                    // stray
                    fire      = 1'b1;
                    fire_code = '0;
                    status_d  = MB_ST_FAIL;
                end
                MB_COLLECT: begin
                    if (enough) begin
                        // complete
                        fire     = 1'b1;
                        status_d = (cur_code_q == '0) ? MB_ST_FAIL : result;
                        state_d  = MB_IDLE;
                        code_d   = '0;
                    end
                end
                default: state_d = MB_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
    import mbx_pkg::*;
#(
    parameter int NUM_CMDS  = 10,
    parameter int MAX_WORDS = 8,
    parameter logic [NUM_CMDS-1:0][7:0] REQ_BYTES =
        {8'd8, 8'd0, 8'd16, 8'd0, 8'd8, 8'd32, 8'd0, 8'd0, 8'd24, 8'd0},
    localparam int CMD_W = (NUM_CMDS > 1) ? $clog2(NUM_CMDS) : 1,
    localparam int CNT_W = $clog2(MAX_WORDS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [MB_ADDR_W-1:0]    reg_addr,
    input  logic [31:0]             reg_wdata,
    input  logic [MB_ADDR_W-1:0]    reg_rd_addr,
    output logic [31:0]             reg_rdata,
    output logic                    exec_valid,
    output logic [CMD_W-1:0]        exec_cmd,
    output logic [MAX_WORDS*32-1:0] exec_args,
    input  logic [31:0]             exec_result,
    output logic                    arg_overflow
);
    logic             cmd_wr, data_wr;
    logic [CMD_W-1:0] new_code, cur_code_q;
    logic [7:0]       new_req, cur_req;
    logic [CNT_W-1:0] cnt_q, cnt_next;
    logic [31:0]      status_q;
    mb_state_e        state_q;

    assign cmd_wr  = reg_wr && (reg_addr == MB_OFF_CMD);
    assign data_wr = reg_wr && (reg_addr == MB_OFF_DATA);

    mbx_cmd_decode #(
        .NUM_CMDS (NUM_CMDS),
        .CMD_W    (CMD_W),
        .REQ_BYTES(REQ_BYTES)
    ) u_decode (
        .wr_value(reg_wdata),
        .cur_code(cur_code_q),
        .new_code(new_code),
        .new_req (new_req),
        .cur_req (cur_req)
    );

    mbx_arg_buffer #(
        .MAX_WORDS(MAX_WORDS),
        .CNT_W    (CNT_W)
    ) u_args (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (data_wr),
        .push_data(reg_wdata),
        .clr_cnt  (cmd_wr || exec_valid),
        .clr_ovf  (cmd_wr),
        .cnt_q    (cnt_q),
        .cnt_next (cnt_next),
        .ovf_q    (arg_overflow),
        .args_view(exec_args)
    );

    mbx_fsm #(
        .CMD_W(CMD_W),
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .data_wr   (data_wr),
        .new_code  (new_code),
        .new_req   (new_req),
        .cur_req   (cur_req),
        .cnt_next  (cnt_next),
        .result    (exec_result),
        .state_q   (state_q),
        .cur_code_q(cur_code_q),
        .status_q  (status_q),
        .fire      (exec_valid),
        .fire_code (exec_cmd)
    );

    assign reg_rdata = (reg_rd_addr == MB_OFF_STATUS) ? status_q : 32'd0;
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
    import mbx_pkg::*;
#(
    parameter int NUM_CMDS  = 10,
    parameter int MAX_WORDS = 8,
    parameter int CMD_W     = 4,
    parameter int CNT_W     = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [7:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             exec_valid,
    input logic [CMD_W-1:0] exec_cmd,
    input logic             arg_overflow,
    input logic [CNT_W-1:0] cnt_q,
    input logic [31:0]      status_q
);
    logic cmd_wr;
    assign cmd_wr = reg_wr && (reg_addr == MB_OFF_CMD);

    a_r1_bad_code_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !((reg_wdata != 32'd0) && (reg_wdata < 32'(NUM_CMDS))))
        |-> (exec_valid && (exec_cmd == '0)));

    a_r2_need_data: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !exec_valid) |=> (status_q == MB_ST_NEED));

    a_r5_counter_clears: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |=> (cnt_q == '0));

    a_r6_reserved_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && (exec_cmd == '0)) |=> (status_q == MB_ST_FAIL));

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (arg_overflow && !cmd_wr) |=> arg_overflow);

    a_r8_ovf_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> !arg_overflow);

    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) <= 32'(MAX_WORDS));
endmodule

bind cmd_mailbox mbx_checker #(
    .NUM_CMDS (NUM_CMDS),
    .MAX_WORDS(MAX_WORDS),
    .CMD_W    (CMD_W),
    .CNT_W    (CNT_W)
) u_mbx_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .exec_valid  (exec_valid),
    .exec_cmd    (exec_cmd),
    .arg_overflow(arg_overflow),
    .cnt_q       (cnt_q),
    .status_q    (status_q)
);

// File: tb/test_cmd_mailbox.sv
module test_cmd_mailbox;
    localparam logic [31:0] ST_FAIL = 32'hFFFF_FFFF;
    localparam logic [31:0] ST_NEED = 32'hFFFF_FFFE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    // main instance
    logic         reg_wr = 1'b0;
    logic [7:0]   reg_addr = 8'h00, reg_rd_addr = 8'h08;
    logic [31:0]  reg_wdata = 32'd0, reg_rdata, exec_result;
    logic         exec_valid, arg_overflow;
    logic [3:0]   exec_cmd;
    logic [255:0] exec_args;

    assign exec_result = {8'h5A, exec_args[23:0]} ^ 32'(exec_cmd);

    cmd_mailbox i_cmd_mailbox (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rd_addr(reg_rd_addr), .reg_rdata(reg_rdata),
        .exec_valid(exec_valid), .exec_cmd(exec_cmd), .exec_args(exec_args),
        .exec_result(exec_result), .arg_overflow(arg_overflow)
    );

    // small instance for overflow
    logic        s_wr = 1'b0;
    logic [7:0]  s_addr = 8'h00;
    logic [31:0] s_wdata = 32'd0, s_rdata;
    logic        s_valid, s_ovf;
    logic [1:0]  s_cmd;
    logic [63:0] s_args;

    cmd_mailbox #(
        .NUM_CMDS(4), .MAX_WORDS(2),
        .REQ_BYTES({8'd16, 8'd8, 8'd0, 8'd0})
    ) i_cmd_mailbox_small (
        .clk(clk), .rst_n(rst_n), .reg_wr(s_wr), .reg_addr(s_addr),
        .reg_wdata(s_wdata), .reg_rd_addr(8'h08), .reg_rdata(s_rdata),
        .exec_valid(s_valid), .exec_cmd(s_cmd), .exec_args(s_args),
        .exec_result(32'h0000_C0DE), .arg_overflow(s_ovf)
    );

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // reference model
    int          m_cur = 0, m_cnt = 0;
    logic [31:0] m_status = 32'd0;
    logic        m_ovf = 1'b0;
    logic [31:0] m_buf [8];

    function automatic int req_bytes(input int code);
        case (code)
            1: return 24;
            4: return 32;
            5: return 8;
            7: return 16;
            9: return 8;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] res_of(input int code, input logic [31:0] w0);
        return {8'h5A, w0[23:0]} ^ 32'(code);
    endfunction

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] args_e [8];
        bit fire_e = 1'b0;
        int code_e = 0, ncnt;
        string tag;
        for (int i = 0; i < 8; i++) args_e[i] = m_buf[i];
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        #1;
        if (a == 8'h00) begin
            tag = "R3";
            code_e = (d != 0 && d < 10) ? int'(d) : 0;
            m_cnt = 0; m_ovf = 1'b0;
            if (req_bytes(code_e) == 0) begin
                fire_e = 1'b1;
                m_status = (code_e == 0) ? ST_FAIL : res_of(code_e, args_e[0]);
                m_cur = 0;
            end else begin
                m_status = ST_NEED; m_cur = code_e;
            end
        end else if (a == 8'h04) begin
            tag = "R4";
            if (m_cnt < 8) begin
                args_e[m_cnt] = d; m_buf[m_cnt] = d; ncnt = m_cnt + 1;
            end else begin
                m_ovf = 1'b1; ncnt = m_cnt;
            end
            if (ncnt * 4 >= req_bytes(m_cur)) begin
                fire_e = 1'b1; code_e = m_cur;
                m_status = (m_cur == 0) ? ST_FAIL : res_of(m_cur, args_e[0]);
                m_cnt = 0; m_cur = 0;
            end else begin
                m_cnt = ncnt;
            end
        end else begin
            tag = "R9";
        end
        chk(tag, "exec_valid", 32'(exec_valid), 32'(fire_e));
        if (fire_e) begin
            chk(tag, "exec_cmd", 32'(exec_cmd), 32'(code_e));
            for (int i = 0; i < 8; i++)
                chk(tag, "exec_args word", exec_args[32*i +: 32], args_e[i]);
        end
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
        chk("R5", "status", reg_rdata, m_status);
        chk("R8", "overflow", 32'(arg_overflow), 32'(m_ovf));
    endtask

    task automatic s_write(input logic [7:0] a, input logic [31:0] d,
                           input logic exp_fire);
        @(negedge clk);
        s_wr = 1'b1; s_addr = a; s_wdata = d;
        #1;
        chk("R8", "small exec_valid", 32'(s_valid), 32'(exp_fire));
        @(posedge clk);
        #1;
        s_wr = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_v;
        int r;
        logic [31:0] v;
        seed_v = $urandom(32'd2024);
        for (int i = 0; i < 8; i++) m_buf[i] = 32'd0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10 reset state
        chk("R10", "status after reset", reg_rdata, 32'h0000_0000);
        chk("R10", "exec_valid after reset", 32'(exec_valid), 32'd0);
        chk("R10", "overflow after reset", 32'(arg_overflow), 32'd0);

        // R6 stray data write with no command
        do_write(8'h04, 32'h1111_2222);
        chk("R6", "stray status fail", reg_rdata, ST_FAIL);
        // R3 R7 bus reset fires at once
        do_write(8'h00, 32'd6);
        chk("R7", "bus reset status", reg_rdata, res_of(6, m_buf[0]));
        // R7 configure needs 6 words
        do_write(8'h00, 32'd1);
        chk("R2", "need data status", reg_rdata, ST_NEED);
        for (int i = 0; i < 5; i++) do_write(8'h04, 32'hC0F0_0000 + 32'(i));
        chk("R7", "configure not fired after 5 words", reg_rdata, ST_NEED);
        do_write(8'h04, 32'hC0F0_0005);
        chk("R7", "configure fired on word 6", reg_rdata, res_of(1, 32'hC0F0_0000));
        // R1 invalid codes
        do_write(8'h00, 32'd10);
        chk("R1", "code 10 fails", reg_rdata, ST_FAIL);
        do_write(8'h00, 32'hFFFF_FFF5);
        chk("R1", "large code fails", reg_rdata, ST_FAIL);
        // R9 foreign write ignored mid-collection
        do_write(8'h00, 32'd9);
        do_write(8'h04, 32'hAB00_0001);
        do_write(8'h0C, 32'hDEAD_BEEF);
        chk("R9", "foreign write keeps status", reg_rdata, ST_NEED);
        do_write(8'h04, 32'hAB00_0002);
        chk("R5", "abort result", reg_rdata, res_of(9, 32'hAB00_0001));
        @(negedge clk);
        reg_rd_addr = 8'h0C;
        #1;
        chk("R9", "unmapped read zero", reg_rdata, 32'd0);
        reg_rd_addr = 8'h08;

        // random mix
        for (int n = 0; n < 3000; n++) begin
            r = int'($urandom % 10);
            if (r < 3) begin
                v = ($urandom % 8 == 0) ? $urandom : 32'($urandom % 12);
                do_write(8'h00, v);
            end else if (r < 9) begin
                do_write(8'h04, $urandom);
            end else begin
                do_write(8'h0C, $urandom);
            end
        end

        // R8 overflow on small instance (code 3 needs 16 bytes, depth 2)
        s_write(8'h00, 32'd3, 1'b0);
        chk("R8", "small need data", s_rdata, ST_NEED);
        s_write(8'h04, 32'h0000_00A1, 1'b0);
        s_write(8'h04, 32'h0000_00A2, 1'b0);
        chk("R8", "no overflow when exactly full", 32'(s_ovf), 32'd0);
        s_write(8'h04, 32'h0000_00A3, 1'b0);
        chk("R8", "overflow set", 32'(s_ovf), 32'd1);
        s_write(8'h0C, 32'h0, 1'b0);
        chk("R8", "overflow sticky", 32'(s_ovf), 32'd1);
        s_write(8'h00, 32'd2, 1'b0);
        chk("R8", "overflow cleared by command", 32'(s_ovf), 32'd0);
        s_write(8'h04, 32'h0000_00B1, 1'b0);
        @(negedge clk);
        s_wr = 1'b1; s_addr = 8'h04; s_wdata = 32'h0000_00B2;
        #1;
        chk("R8", "small fires", 32'(s_valid), 32'd1);
        chk("R8", "small word0", s_args[31:0], 32'h0000_00B1);
        chk("R8", "small word1", s_args[63:32], 32'h0000_00B2);
        @(posedge clk);
        #1;
        s_wr = 1'b0;
        chk("R5", "small result latched", s_rdata, 32'h0000_C0DE);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule